// File: doc/BRIEF.md
# Reset-Sampled Mode Configuration Latch

This block reads a few configuration straps when an active-low reset is released and keeps the result as mode bits until the next reset. Two data-bus bits pick the function of two pin groups. For each group the choice is its bus-control or interrupt/clock-select role, or a general-purpose port role. A clock-mode strap picks the on-chip synthesizer or an external clock. The breakpoint line, read as a strap, decides whether debug mode is enabled.

After reset the same breakpoint line works as a runtime request, and so does an internal breakpoint signal. Each request is routed according to the latched debug enable. With debug enabled it becomes a debug-entry pulse. With debug disabled it becomes a breakpoint-exception pulse.

The raw reset goes through a synchronizer: it asserts asynchronously and releases synchronously. The straps pass through synchronizers of the same depth, so a strap is read at the last clock edge before the reset pin rises. All pins here are plain control levels or pulses. Nothing flows as a stream, so there is no valid/ready handshake.

Top module: `rst_mode_latch`

## Requirements
- R1: While reset is asserted, and before the first release, the outputs are grp_a_port_o=0, grp_b_port_o=0, synth_en_o=1 and dbg_en_o=0.
- R2: grp_a_port_o becomes 1 when strap_a_i is low at reset release. It becomes 0 when strap_a_i is high at release.
- R3: grp_b_port_o becomes 1 when strap_b_i is low at reset release. It becomes 0 when strap_b_i is high at release.
- R4: synth_en_o becomes the level of clk_sel_i at reset release: 1 selects the synthesizer, 0 selects the external clock.
- R5: dbg_en_o becomes 1 when brk_n_i is low at reset release, and 0 when it is high. Holding brk_n_i low for two cycles right before the release is enough for it to latch. Driving it high one cycle before the release gives 0.
- R6: After release the mode outputs do not change when any strap input changes. Every later reset release reads the straps again.
- R7: No dbg_enter_o or brk_exc_o pulse appears while reset is asserted, whatever brk_n_i and int_brk_i do.
- R8: After brk_n_i has been seen high, a falling edge on brk_n_i gives exactly one single-cycle pulse. The pulse is visible in the third cycle after the input falls. It goes to dbg_enter_o when dbg_en_o=1 and to brk_exc_o when dbg_en_o=0.
- R9: A one-cycle high on int_brk_i after release gives exactly one single-cycle pulse in the following cycle, routed as in R8.
- R10: If brk_n_i is still low from the strap after release, it produces no pulse until it has first been seen high.
- R11: dbg_enter_o and brk_exc_o are never high together, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Raw active-low reset, asynchronous assert |
| strap_a_i | input | 1 | Data strap for pin group A (low = port function) |
| strap_b_i | input | 1 | Data strap for pin group B (low = port function) |
| clk_sel_i | input | 1 | Clock-mode strap (high = synthesizer) |
| brk_n_i | input | 1 | Active-low breakpoint: strap at release, request afterwards |
| int_brk_i | input | 1 | Internal breakpoint request, active high, synchronous |
| grp_a_port_o | output | 1 | Pin group A assigned to general port |
| grp_b_port_o | output | 1 | Pin group B assigned to general port |
| synth_en_o | output | 1 | Clock synthesizer selected |
| dbg_en_o | output | 1 | Debug mode enabled |
| dbg_enter_o | output | 1 | Debug-entry pulse |
| brk_exc_o | output | 1 | Breakpoint-exception pulse |

## Verification
The capture is exercised with random strap combinations and random reset lengths. This shows whether each mode bit follows its own strap and polarity, and whether any two straps have been swapped. Two directed cases place the breakpoint strap edge one or two cycles before the release, which checks at exactly which edge the strap is read. After each release the straps are changed to check that the mode bits hold. Breakpoint requests are tried from the external line and the internal line, under both debug settings. This separates correct routing, correct latency and the single-pulse width from an idle line. A breakpoint line left low from the strap checks that the first-cycle guard suppresses a request.

// File: rtl/rsml_pkg.sv
package rsml_pkg;
  localparam int STRAP_W = 4;
  localparam int IDX_A   = 0;
  localparam int IDX_B   = 1;
  localparam int IDX_CLK = 2;
  localparam int IDX_BRK = 3;

  typedef struct packed {
    logic grp_a_port;
    logic grp_b_port;
    logic synth_en;
    logic dbg_en;
  } mode_t;

  localparam mode_t MODE_DEFAULT = '{grp_a_port: 1'b0, grp_b_port: 1'b0,
                                     synth_en: 1'b1, dbg_en: 1'b0};
endpackage

// File: rtl/rsml_sync.sv
module rsml_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) pipe[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) pipe[s] <= pipe[s-1];
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rsml_rst_sync.sv
module rsml_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rel_o,
  output logic active_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  // high in the cycle before the synchronized reset releases
  assign rel_o    = chain[STAGES-2] & ~chain[STAGES-1];
  assign active_o = chain[STAGES-1];
endmodule

// File: rtl/rsml_mode_cap.sv
module rsml_mode_cap
  import rsml_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rel_i,
  input  logic               active_i,
  input  logic [STRAP_W-1:0] strap_i,
  output mode_t              mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_DEFAULT;
    else if (rel_i) begin
      mode_q.grp_a_port <= ~strap_i[IDX_A];
      mode_q.grp_b_port <= ~strap_i[IDX_B];
      mode_q.synth_en   <=  strap_i[IDX_CLK];
      mode_q.dbg_en     <= ~strap_i[IDX_BRK];
    end
  end

  assign mode_o = mode_q;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && $past(active_i)) |-> $stable(mode_q)); // R6

  AST_DEFAULT_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !$past(active_i) && !rel_i) |-> (mode_q == MODE_DEFAULT)); // R1
endmodule

// File: rtl/rsml_brk_route.sv
module rsml_brk_route (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic brk_n_s_i,
  input  logic int_brk_i,
  input  logic dbg_en_i,
  output logic dbg_enter_o,
  output logic brk_exc_o
);
  logic armed_q;
  logic brk_d_q;
  logic int_d_q;
  logic ext_fall;
  logic int_rise;
  logic req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      brk_d_q <= 1'b0;
      int_d_q <= 1'b0;
    end else begin
      armed_q <= active_i & (armed_q | brk_n_s_i);
      brk_d_q <= brk_n_s_i;
      int_d_q <= int_brk_i;
    end
  end

  assign ext_fall = armed_q & brk_d_q & ~brk_n_s_i;
  assign int_rise = int_brk_i & ~int_d_q;
  assign req      = active_i & (ext_fall | int_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_enter_o <= 1'b0;
      brk_exc_o   <= 1'b0;
    end else begin
      dbg_enter_o <= req &  dbg_en_i;
      brk_exc_o   <= req & ~dbg_en_i;
    end
  end

  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !(dbg_enter_o || brk_exc_o)); // R7

  AST_ENTER_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter_o |-> dbg_en_i); // R8

  AST_EXC_NEEDS_NO_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    brk_exc_o |-> !dbg_en_i); // R8

  AST_ENTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter_o |=> !dbg_enter_o); // R11

  AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_exc_o |=> !brk_exc_o); // R11

  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_enter_o && brk_exc_o)); // R11

  AST_UNARMED_EXT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !int_rise) |=> !(dbg_enter_o || brk_exc_o)); // R10
endmodule

// File: rtl/rst_mode_latch.sv
module rst_mode_latch
  import rsml_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_a_i,
  input  logic strap_b_i,
  input  logic clk_sel_i,
  input  logic brk_n_i,
  input  logic int_brk_i,
  output logic grp_a_port_o,
  output logic grp_b_port_o,
  output logic synth_en_o,
  output logic dbg_en_o,
  output logic dbg_enter_o,
  output logic brk_exc_o
);
  logic [STRAP_W-1:0] strap_raw;
  logic [STRAP_W-1:0] strap_s;
  logic               rel;
  logic               active;
  mode_t              mode;

  always_comb begin
    strap_raw          = '0;
    strap_raw[IDX_A]   = strap_a_i;
    strap_raw[IDX_B]   = strap_b_i;
    strap_raw[IDX_CLK] = clk_sel_i;
    strap_raw[IDX_BRK] = brk_n_i;
  end

  rsml_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (strap_raw),
    .q_o (strap_s)
  );

  rsml_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel_o    (rel),
    .active_o (active)
  );

  rsml_mode_cap u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel_i    (rel),
    .active_i (active),
    .strap_i  (strap_s),
    .mode_o   (mode)
  );

  rsml_brk_route u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .brk_n_s_i   (strap_s[IDX_BRK]),
    .int_brk_i   (int_brk_i),
    .dbg_en_i    (mode.dbg_en),
    .dbg_enter_o (dbg_enter_o),
    .brk_exc_o   (brk_exc_o)
  );

  assign grp_a_port_o = mode.grp_a_port;
  assign grp_b_port_o = mode.grp_b_port;
  assign synth_en_o   = mode.synth_en;
  assign dbg_en_o     = mode.dbg_en;
endmodule

// File: tb/rst_mode_latch_tb.sv
module rst_mode_latch_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic strap_a = 1'b1, strap_b = 1'b1, clk_sel = 1'b1, brk_n = 1'b1, int_brk = 1'b0;
  logic grp_a, grp_b, synth_en, dbg_en, dbg_enter, brk_exc;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  rst_mode_latch dut_i (
    .clk (clk), .rst_n (rst_n),
    .strap_a_i (strap_a), .strap_b_i (strap_b), .clk_sel_i (clk_sel),
    .brk_n_i (brk_n), .int_brk_i (int_brk),
    .grp_a_port_o (grp_a), .grp_b_port_o (grp_b), .synth_en_o (synth_en),
    .dbg_en_o (dbg_en), .dbg_enter_o (dbg_enter), .brk_exc_o (brk_exc)
  );

  function automatic logic [3:0] exp_mode(logic a, logic b, logic ck, logic bk);
    return {~a, ~b, ck, ~bk};
  endfunction

  function automatic logic [3:0] cur_mode();
    return {grp_a, grp_b, synth_en, dbg_en};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // samples outputs on n falling edges; counts pulses and first cycle seen
  task automatic watch(int n, output int ne, output int nx, output int first);
    ne = 0; nx = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (dbg_enter) ne++;
      if (brk_exc) nx++;
      if ((dbg_enter || brk_exc) && first == 0) first = i;
    end
  endtask

  task automatic do_reset(logic a, logic b, logic ck, logic bk, int hold);
    @(negedge clk);
    rst_n = 1'b0;
    strap_a = a; strap_b = b; clk_sel = ck; brk_n = bk;
    repeat (hold) @(negedge clk);
    chk("R1 defaults in reset", cur_mode(), 4'b0010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 R3 R4 R5 captured mode", cur_mode(), exp_mode(a, b, ck, bk));
  endtask

  task automatic ext_req();
    int ne, nx, first;
    logic d = dbg_en;
    brk_n = 1'b1;
    repeat (4) @(negedge clk);
    brk_n = 1'b0;
    watch(6, ne, nx, first);
    chk("R8 ext enter count", ne, d ? 1 : 0);
    chk("R8 ext exception count", nx, d ? 0 : 1);
    chk("R8 ext latency", first, 3);
    brk_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic int_req();
    int ne, nx, first;
    logic d = dbg_en;
    int_brk = 1'b1;
    @(negedge clk);
    int_brk = 1'b0;
    chk("R9 int pulse next cycle", {dbg_enter, brk_exc}, d ? 2'b10 : 2'b01);
    watch(5, ne, nx, first);
    chk("R11 int single pulse", ne + nx, 0);
  endtask

  initial begin
    int ne, nx, first;
    logic [3:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 defaults before first release", cur_mode(), 4'b0010);

    // R7: activity during reset yields nothing
    brk_n = 1'b0; int_brk = 1'b1;
    @(negedge clk); brk_n = 1'b1; int_brk = 1'b0;
    @(negedge clk); brk_n = 1'b0; int_brk = 1'b1;
    watch(3, ne, nx, first);
    chk("R7 no pulse in reset", ne + nx, 0);
    int_brk = 1'b0;

    // directed straps
    do_reset(1'b0, 1'b1, 1'b0, 1'b0, 4);
    // R10: strap-low breakpoint left low after release stays silent
    watch(8, ne, nx, first);
    chk("R10 stale strap level ignored", ne + nx, 0);
    ext_req();
    int_req();

    // R6: straps change after release, modes hold
    held = cur_mode();
    strap_a = ~strap_a; strap_b = ~strap_b; clk_sel = ~clk_sel;
    repeat (4) @(negedge clk);
    chk("R6 modes hold", cur_mode(), held);

    do_reset(1'b1, 1'b0, 1'b1, 1'b1, 5);
    ext_req();
    int_req();

    // R5 corner: breakpoint low two cycles before release
    @(negedge clk); rst_n = 1'b0; brk_n = 1'b1;
    repeat (4) @(negedge clk);
    brk_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 low two cycles before release", dbg_en, 1);

    // R5 corner: breakpoint high one cycle before release
    @(negedge clk); rst_n = 1'b0; brk_n = 1'b0;
    repeat (4) @(negedge clk);
    brk_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 high one cycle before release", dbg_en, 0);

    // random sweep
    for (int it = 0; it < 30; it++) begin
      logic [3:0] r = 4'($urandom);
      do_reset(r[0], r[1], r[2], r[3], 2 + int'($urandom % 6));
      held = cur_mode();
      strap_a = $urandom; strap_b = $urandom; clk_sel = $urandom;
      if ($urandom % 2) ext_req(); else int_req();
      chk("R6 modes hold after traffic", cur_mode(), held);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule